// File: doc/BRIEF.md
# Call and Return Stack-Frame Sequencer

This block carries out the memory traffic a processor core needs when it enters or leaves a subroutine. On a call it pushes a return address, keeps one unused slot beside it for a static-chain pointer, and pushes the caller's frame pointer. It then hands back new stack pointer, frame pointer and program counter values. On a return it unwinds the same frame. The stack therefore moves by 12 bytes for every frame.

The register file stays outside the block. The current stack pointer, frame pointer and program counter arrive on input ports. The new values leave on output ports, each with a write strobe, in the one cycle in which `done` is high. Memory is reached through a single-word request/acknowledge port. Each access holds its request until the memory acknowledges it, so any memory latency is tolerated.

A call command comes with a kind bit that selects how far past the call's PC the return address lies. An absolute-target call is 6 bytes long and a register-target call is 2 bytes long. Only one command runs at a time, and commands that arrive while the sequencer is busy are dropped.

Top module: `callret_frame_seq`

## Requirements
- R1: While reset is held and in the first idle cycle after it, `busy`, `done`, `mem_req` and all three write strobes are low.
- R2: The first memory access of a call is a write (`mem_we`=1) of the return address to address SP-8.
- R3: The second memory access of a call is a write of the incoming frame pointer value to address SP-12.
- R4: A call finishes with one `done` cycle. In that cycle SP and FP are written with SP-12, PC is written with the call target, and all three strobes are high.
- R5: The return address is PC+6 when `call_kind`=0 (absolute target) and PC+2 when `call_kind`=1 (register target).
- R6: A return reads (`mem_we`=0) the new FP from address FP and then the new PC from address FP+4. It finishes with one `done` cycle that writes SP=FP+12 together with the loaded FP and PC, with all strobes high.
- R7: Each memory request keeps its address, direction and write data unchanged until the cycle in which `mem_ack` is seen. The sequence advances only on acknowledge.
- R8: A `call_req` or `ret_req` raised while `busy` is high has no effect on memory traffic or results, and produces no extra `done`.
- R9: If `call_req` and `ret_req` are both high in an idle cycle, the call is performed and the return is dropped.
- R10: The two least significant bits of the incoming SP and FP are treated as zero. Every memory address has its low two bits equal to zero.
- R11: Stack arithmetic wraps modulo 2^32. For example, a call with SP=4 writes at 0xFFFFFFFC and 0xFFFFFFF8.
- R12: `done` lasts exactly one cycle per accepted command. `busy` rises only in the cycle after a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Start a call sequence (sampled while idle) |
| call_kind | input | 1 | 0: absolute-target call (PC+6), 1: register-target call (PC+2) |
| call_target | input | 32 | Destination PC for the call |
| ret_req | input | 1 | Start a return sequence (sampled while idle) |
| sp_in | input | 32 | Current stack pointer |
| fp_in | input | 32 | Current frame pointer |
| pc_in | input | 32 | PC of the call instruction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_out | output | 32 | New stack pointer |
| fp_we | output | 1 | Frame pointer write strobe |
| fp_out | output | 32 | New frame pointer |
| pc_we | output | 1 | Program counter write strobe |
| pc_out | output | 32 | New program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench builds the block with its defaults: a 32-bit data path, 4-byte words, and return offsets of 6 and 2. These values let a stack pointer near zero wrap through 0xFFFFFFFC. They also let an unaligned SP such as 0x1003 exercise the masking of the two low bits. The bench's memory model answers after 0 to 3 wait cycles, so a request is held across several cycles. A call followed by its matching return shows that the frame written is the frame read back. While a sequence runs, the bench keeps firing call and return commands with unrelated operands to show they are dropped.

// File: rtl/callret_pkg.sv
package callret_pkg;

  // Sequencer states. The push states precede the pop states only for readability.
  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_PUSH_RA = 3'd1,
    SQ_PUSH_FP = 3'd2,
    SQ_END_CAL = 3'd3,
    SQ_POP_FP  = 3'd4,
    SQ_POP_PC  = 3'd5,
    SQ_END_RET = 3'd6
  } seq_state_e;

  function automatic logic is_mem_state(seq_state_e s);
    return (s == SQ_PUSH_RA) || (s == SQ_PUSH_FP) ||
           (s == SQ_POP_FP)  || (s == SQ_POP_PC);
  endfunction

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call_req,
  input  logic       ret_req,
  input  logic       mem_ack,
  output seq_state_e state,
  output logic       accept_call,
  output logic       accept_ret,
  output logic       busy,
  output logic       done
);

  seq_state_e state_nx;

  always_comb begin
    accept_call = (state == SQ_IDLE) && call_req;
    accept_ret  = (state == SQ_IDLE) && ret_req && !call_req;
    state_nx    = state;
    unique case (state)
      SQ_IDLE: begin
        if (accept_call)     state_nx = SQ_PUSH_RA;
        else if (accept_ret) state_nx = SQ_POP_FP;
      end
      SQ_PUSH_RA: if (mem_ack) state_nx = SQ_PUSH_FP;
      SQ_PUSH_FP: if (mem_ack) state_nx = SQ_END_CAL;
      SQ_POP_FP:  if (mem_ack) state_nx = SQ_POP_PC;
      SQ_POP_PC:  if (mem_ack) state_nx = SQ_END_RET;
      SQ_END_CAL: state_nx = SQ_IDLE;
      SQ_END_RET: state_nx = SQ_IDLE;
      default:    state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nx;
  end

  assign busy = (state != SQ_IDLE);
  assign done = (state == SQ_END_CAL) || (state == SQ_END_RET);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(call_req || ret_req));

endmodule

// File: rtl/callret_dpath.sv
module callret_dpath
  import callret_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LONG_STEP  = 6,
  parameter int SHORT_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic              accept_call,
  input  logic              accept_ret,
  input  logic              call_kind,
  input  logic [DATA_W-1:0] call_target,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] pc_in,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_out,
  output logic              fp_we,
  output logic [DATA_W-1:0] fp_out,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_out
);

  localparam int LSB_W = $clog2(WORD_BYTES);
  localparam logic [DATA_W-1:0] SLOT     = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] RA_GAP   = DATA_W'(2 * WORD_BYTES);
  localparam logic [DATA_W-1:0] POP_SKIP = DATA_W'(2 * WORD_BYTES);
  localparam logic [DATA_W-1:0] LONG_D   = DATA_W'(LONG_STEP);
  localparam logic [DATA_W-1:0] SHORT_D  = DATA_W'(SHORT_STEP);

  logic [DATA_W-1:0] sp_al, fp_al;

  generate
    if (LSB_W > 0) begin : g_align
      assign sp_al = {sp_in[DATA_W-1:LSB_W], {LSB_W{1'b0}}};
      assign fp_al = {fp_in[DATA_W-1:LSB_W], {LSB_W{1'b0}}};
    end else begin : g_noalign
      assign sp_al = sp_in;
      assign fp_al = fp_in;
    end
  endgenerate

  // Working stack pointer, link word (return address / loaded PC),
  // frame word (caller FP / loaded FP) and call destination.
  logic [DATA_W-1:0] stk_q, stk_nx;
  logic [DATA_W-1:0] link_q, link_nx;
  logic [DATA_W-1:0] frame_q, frame_nx;
  logic [DATA_W-1:0] dest_q;
  logic              stk_en, link_en, frame_en, dest_en;
  logic              step;

  assign step = mem_ack && is_mem_state(state);

  always_comb begin
    stk_nx   = stk_q;
    link_nx  = link_q;
    frame_nx = frame_q;
    stk_en   = 1'b0;
    link_en  = 1'b0;
    frame_en = 1'b0;
    dest_en  = accept_call;
    if (accept_call) begin
      stk_en   = 1'b1;
      stk_nx   = sp_al - RA_GAP;
      link_en  = 1'b1;
      link_nx  = pc_in + (call_kind ? SHORT_D : LONG_D);
      frame_en = 1'b1;
      frame_nx = fp_in;
    end else if (accept_ret) begin
      stk_en = 1'b1;
      stk_nx = fp_al;
    end else if (step) begin
      unique case (state)
        SQ_PUSH_RA: begin
          stk_en = 1'b1;
          stk_nx = stk_q - SLOT;
        end
        SQ_POP_FP: begin
          stk_en   = 1'b1;
          stk_nx   = stk_q + SLOT;
          frame_en = 1'b1;
          frame_nx = mem_rdata;
        end
        SQ_POP_PC: begin
          stk_en  = 1'b1;
          stk_nx  = stk_q + POP_SKIP;
          link_en = 1'b1;
          link_nx = mem_rdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q   <= '0;
      link_q  <= '0;
      frame_q <= '0;
      dest_q  <= '0;
    end else begin
      if (stk_en)   stk_q   <= stk_nx;
      if (link_en)  link_q  <= link_nx;
      if (frame_en) frame_q <= frame_nx;
      if (dest_en)  dest_q  <= call_target;
    end
  end

  always_comb begin
    mem_req   = is_mem_state(state);
    mem_we    = (state == SQ_PUSH_RA) || (state == SQ_PUSH_FP);
    mem_addr  = stk_q;
    mem_wdata = (state == SQ_PUSH_FP) ? frame_q : link_q;
    sp_we     = (state == SQ_END_CAL) || (state == SQ_END_RET);
    fp_we     = sp_we;
    pc_we     = sp_we;
    sp_out    = stk_q;
    fp_out    = (state == SQ_END_CAL) ? stk_q  : frame_q;
    pc_out    = (state == SQ_END_CAL) ? dest_q : link_q;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/callret_frame_seq.sv
module callret_frame_seq
  import callret_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LONG_STEP  = 6,
  parameter int SHORT_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              call_kind,
  input  logic [DATA_W-1:0] call_target,
  input  logic              ret_req,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] fp_in,
  input  logic [DATA_W-1:0] pc_in,
  output logic              busy,
  output logic              done,
  output logic              sp_we,
  output logic [DATA_W-1:0] sp_out,
  output logic              fp_we,
  output logic [DATA_W-1:0] fp_out,
  output logic              pc_we,
  output logic [DATA_W-1:0] pc_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int LSB_W = $clog2(WORD_BYTES);

  seq_state_e state;
  logic       accept_call, accept_ret;

  callret_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_req    (call_req),
    .ret_req     (ret_req),
    .mem_ack     (mem_ack),
    .state       (state),
    .accept_call (accept_call),
    .accept_ret  (accept_ret),
    .busy        (busy),
    .done        (done)
  );

  callret_dpath #(
    .DATA_W     (DATA_W),
    .WORD_BYTES (WORD_BYTES),
    .LONG_STEP  (LONG_STEP),
    .SHORT_STEP (SHORT_STEP)
  ) u_dpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .accept_call (accept_call),
    .accept_ret  (accept_ret),
    .call_kind   (call_kind),
    .call_target (call_target),
    .sp_in       (sp_in),
    .fp_in       (fp_in),
    .pc_in       (pc_in),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .sp_we       (sp_we),
    .sp_out      (sp_out),
    .fp_we       (fp_we),
    .fp_out      (fp_out),
    .pc_we       (pc_we),
    .pc_out      (pc_out)
  );

  // R4
  strobe_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we || fp_we || pc_we) |-> done);

  // R8
  no_req_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  generate
    if (LSB_W > 0) begin : g_align_chk
      // R10
      addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LSB_W-1:0] == '0));
    end
  endgenerate

endmodule

// File: tb/test_callret_frame_seq.sv
module test_callret_frame_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        call_req, call_kind, ret_req;
  logic [31:0] call_target, sp_in, fp_in, pc_in;
  logic        busy, done, sp_we, fp_we, pc_we;
  logic [31:0] sp_out, fp_out, pc_out;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;

  callret_frame_seq i_callret_frame_seq (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .call_kind(call_kind),
    .call_target(call_target), .ret_req(ret_req), .sp_in(sp_in),
    .fp_in(fp_in), .pc_in(pc_in), .busy(busy), .done(done),
    .sp_we(sp_we), .sp_out(sp_out), .fp_we(fp_we), .fp_out(fp_out),
    .pc_we(pc_we), .pc_out(pc_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  // Scoreboard queues
  logic [31:0] exp_m_addr[$];
  logic [31:0] exp_m_data[$];
  logic        exp_m_we[$];
  logic [31:0] exp_m_tag[$];
  logic [31:0] exp_d_sp[$];
  logic [31:0] exp_d_fp[$];
  logic [31:0] exp_d_pc[$];
  logic [31:0] exp_d_tag[$];

  logic [31:0] mem_model [logic [31:0]];
  int ack_wait = 0;
  int wcnt = 0;

  function automatic logic [31:0] rd_model(logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory responder and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else begin
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (exp_m_addr.size() == 0) begin
          check("R8 unexpected access", 32'h1, 32'h0);
        end else if (wcnt < ack_wait) begin
          wcnt++;
          check("R7 addr held", mem_addr, exp_m_addr[0]);
        end else begin
          string t;
          t = $sformatf("%s addr", exp_m_tag[0]);
          check(t, mem_addr, exp_m_addr[0]);
          t = $sformatf("%s dir", exp_m_tag[0]);
          check(t, {31'h0, mem_we}, {31'h0, exp_m_we[0]});
          if (exp_m_we[0]) begin
            t = $sformatf("%s wdata", exp_m_tag[0]);
            check(t, mem_wdata, exp_m_data[0]);
            mem_model[mem_addr] = mem_wdata;
          end else begin
            mem_rdata = rd_model(mem_addr);
          end
          void'(exp_m_addr.pop_front());
          void'(exp_m_data.pop_front());
          void'(exp_m_we.pop_front());
          void'(exp_m_tag.pop_front());
          wcnt = 0;
          mem_ack = 1'b1;
        end
      end
      if (done) begin
        if (exp_d_sp.size() == 0) begin
          check("R12 unexpected done", 32'h1, 32'h0);
        end else begin
          string t;
          t = $sformatf("%s sp", exp_d_tag[0]);
          check(t, sp_out, exp_d_sp[0]);
          t = $sformatf("%s fp", exp_d_tag[0]);
          check(t, fp_out, exp_d_fp[0]);
          t = $sformatf("%s pc", exp_d_tag[0]);
          check(t, pc_out, exp_d_pc[0]);
          t = $sformatf("%s strobes", exp_d_tag[0]);
          check(t, {29'h0, sp_we, fp_we, pc_we}, 32'h7);
          void'(exp_d_sp.pop_front());
          void'(exp_d_fp.pop_front());
          void'(exp_d_pc.pop_front());
          void'(exp_d_tag.pop_front());
        end
      end else if (sp_we || fp_we || pc_we) begin
        check("R4 strobe without done", 32'h1, 32'h0);
      end
    end
  end

  task automatic push_mem(logic we, logic [31:0] a, logic [31:0] d, logic [31:0] tag);
    exp_m_we.push_back(we);
    exp_m_addr.push_back(a);
    exp_m_data.push_back(d);
    exp_m_tag.push_back(tag);
  endtask

  task automatic push_done(logic [31:0] s, logic [31:0] f, logic [31:0] p, logic [31:0] tag);
    exp_d_sp.push_back(s);
    exp_d_fp.push_back(f);
    exp_d_pc.push_back(p);
    exp_d_tag.push_back(tag);
  endtask

  // Wait for the completion pulse; optionally fire ignored commands meanwhile.
  task automatic wait_done(bit spam);
    int n = 0;
    forever begin
      @(negedge clk);
      if (done) begin
        call_req = 1'b0;
        ret_req  = 1'b0;
        break;
      end
      if (spam) begin
        call_req    = (n % 2) == 0;
        ret_req     = (n % 3) == 0;
        call_kind   = n[0];
        call_target = 32'hDEAD_0000 + n;
        sp_in       = 32'h7770_0000 + 32'(n * 16);
        fp_in       = 32'h6660_0000 + 32'(n * 16);
        pc_in       = 32'h5550_0000 + n;
      end
      n++;
    end
    @(negedge clk);
  endtask

  task automatic do_call(logic kind, logic [31:0] tgt, logic [31:0] sp,
                         logic [31:0] fp, logic [31:0] pc, bit spam, bit both,
                         logic [31:0] tag);
    logic [31:0] spa, ra;
    spa = sp & ~32'h3;
    ra  = pc + (kind ? 32'd2 : 32'd6);
    push_mem(1'b1, spa - 32'd8, ra, tag);
    push_mem(1'b1, spa - 32'd12, fp, "R3");
    push_done(spa - 32'd12, spa - 32'd12, tgt, "R4");
    @(negedge clk);
    call_kind = kind; call_target = tgt; sp_in = sp; fp_in = fp; pc_in = pc;
    call_req = 1'b1;
    ret_req  = both;
    @(negedge clk);
    call_req = 1'b0;
    ret_req  = 1'b0;
    if (!busy) check("R12 busy after accept", 32'h0, 32'h1);
    else       check("R12 busy after accept", 32'h1, 32'h1);
    wait_done(spam);
  endtask

  task automatic do_ret(logic [31:0] fp, bit spam, logic [31:0] tag);
    logic [31:0] fpa;
    fpa = fp & ~32'h3;
    push_mem(1'b0, fpa, 32'h0, tag);
    push_mem(1'b0, fpa + 32'd4, 32'h0, tag);
    push_done(fpa + 32'd12, rd_model(fpa), rd_model(fpa + 32'd4), tag);
    @(negedge clk);
    fp_in = fp; sp_in = 32'h0BAD_0000; ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_done(spam);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    call_req = 1'b0; ret_req = 1'b0; call_kind = 1'b0;
    call_target = '0; sp_in = '0; fp_in = '0; pc_in = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 reset", {27'h0, busy, done, mem_req, sp_we, fp_we | pc_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {27'h0, busy, done, mem_req, sp_we, fp_we | pc_we}, 32'h0);

    // R2 R5: absolute call, no wait states
    ack_wait = 0;
    do_call(1'b0, 32'h0000_0800, 32'h0000_2000, 32'h0000_3000, 32'h0000_0100, 0, 0, "R5");
    // R6: matching return restores the frame
    do_ret(32'h0000_1FF4, 0, "R6");

    // R5: register-target call with wait states (R7)
    ack_wait = 3;
    do_call(1'b1, 32'h0001_0000, 32'h0000_4000, 32'h0000_4100, 32'h0000_0200, 0, 0, "R2");
    do_ret(32'h0000_3FF4, 0, "R6");

    // R8: commands fired while busy are dropped
    ack_wait = 2;
    do_call(1'b0, 32'h0000_0ABC, 32'h0000_8000, 32'h0000_8800, 32'h0000_0400, 1, 0, "R8");
    do_ret(32'h0000_7FF4, 1, "R8");

    // R9: simultaneous call and return, call wins
    ack_wait = 1;
    do_call(1'b1, 32'h0000_1234, 32'h0000_5000, 32'h0000_5500, 32'h0000_0600, 0, 1, "R9");

    // R10: low address bits ignored
    ack_wait = 0;
    do_call(1'b0, 32'h0000_0040, 32'h0000_1003, 32'h0000_1111, 32'h0000_0700, 0, 0, "R10");
    do_ret(32'h0000_0FF6, 0, "R10");

    // R11: wraparound through zero
    do_call(1'b0, 32'h0000_0090, 32'h0000_0004, 32'h0000_0020, 32'h0000_0030, 0, 0, "R11");
    do_ret(32'hFFFF_FFF8, 0, "R11");

    repeat (4) @(negedge clk);
    // R12: every expected item consumed, nothing left over
    check("R12 pending accesses", 32'(exp_m_addr.size()), 32'h0);
    check("R12 pending done", 32'(exp_d_sp.size()), 32'h0);
    check("R1 idle at end", {30'h0, busy, done}, 32'h0);
    finish_run();
  end

endmodule